// File: doc/BRIEF.md
# Indexed Plug-and-Play Configuration Register Space

This block is a byte-wide slave with two port offsets that opens a plug-and-play configuration space to a host. Software first writes a register index to offset 0, then reads or writes offset 1 to reach the register that index names. Global registers hold a fixed identity code, a revision code and the logical device number. A second group of registers holds activation and a 16-bit I/O base. There is one such bank for each logical device. The logical device number chooses which bank the data window reaches.

Every logical device's activation bit and its I/O base leave the block as flat vectors. Other logic on the chip decodes addresses from them. The host bus protocol that drives the two offsets lies outside this block, as does any address decoding of the exported bases. Reads have no side effects and are combinational from the current state. A write takes effect at the next rising clock edge.

Top module: `cfg_index_space`

## Requirements
- R1: After reset the index register and the logical device number are 0x00, every device is inactive, and every exported base is 0x0000.
- R2: A write at offset 0 (portSel=0) loads the index register. A read at offset 0 returns the index last written. The index stays unchanged across any number of data-window accesses.
- R3: Index 0x20 reads 0xE9 at offset 1, and writes to it change nothing.
- R4: Index 0x27 reads the revision parameter (default 0x01) at offset 1, and writes to it change nothing.
- R5: Index 0x07 is a read/write logical device number. Its value chooses the bank that indexes 0x30, 0x60 and 0x61 reach.
- R6: Index 0x30 holds bit 0 of the data written to it as the activation of the selected device. It reads back as {7'b0, bit}. Only that device's bit in devActive changes.
- R7: Index 0x60 holds bits 15..8 and index 0x61 holds bits 7..0 of the selected device's base. Both read back, and the base appears on devBase[16*n +: 16] for device n.
- R8: A read of any other index at offset 1 returns 0xFF. A write to such an index changes no state.
- R9: When the logical device number is 15 (0x0F) or more, writes to 0x30, 0x60 and 0x61 are ignored, and reads of those indexes return 0xFF. Devices 0x00 to 0x0E (15 devices) are fully banked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portSel | input | 1 | Port offset: 0 = index, 1 = data window |
| wrEn | input | 1 | Write strobe for the selected offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected offset |
| devActive | output | 15 | Activation bit per logical device |
| devBase | output | 240 | 16-bit I/O base per logical device, device n at bits 16n+15..16n |

## Verification
The in-line assertions check three things on every cycle. The write strobes are mutually exclusive. No device's activation or base moves unless a matching strobe fired in the previous cycle, and a per-device strobe is never raised while the device number is out of range. The values themselves can only be shown by the bench's access sequences. These include the fixed identity and revision codes, bank switching between devices, byte placement inside the exported base, the 0xFF fill for unimplemented indexes and the out-of-range bank.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_ID    = 8'h20;
  localparam logic [7:0] IDX_REV   = 8'h27;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_BHI   = 8'h60;
  localparam logic [7:0] IDX_BLO   = 8'h61;
  localparam logic [7:0] ID_CODE   = 8'hE9;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    RS_NONE, RS_INDEX, RS_ID, RS_REV, RS_LDN, RS_ACT, RS_BHI, RS_BLO
  } rdSel_e;

  typedef struct packed {
    logic   idxWr;
    logic   ldnWr;
    logic   actWr;
    logic   hiWr;
    logic   loWr;
    rdSel_e rdSel;
  } cfgStb_t;
endpackage

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
#(
  parameter int NUM_DEV = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portSel,
  input  logic       wrEn,
  input  logic [7:0] idxQ,
  input  logic [7:0] ldnQ,
  output cfgStb_t    stb
);
  localparam logic [7:0] LDN_LIMIT = 8'(NUM_DEV);

  logic devOk;
  logic dataWr;

  assign devOk  = ldnQ < LDN_LIMIT;
  assign dataWr = wrEn && portSel;

  always_comb begin
    stb       = '0;
    stb.rdSel = RS_NONE;
    stb.idxWr = wrEn && !portSel;
    if (!portSel) begin
      stb.rdSel = RS_INDEX;
    end else begin
      unique case (idxQ)
        IDX_ID:  stb.rdSel = RS_ID;
        IDX_REV: stb.rdSel = RS_REV;
        IDX_LDN: begin
          stb.rdSel = RS_LDN;
          stb.ldnWr = dataWr;
        end
        IDX_ACT: if (devOk) begin
          stb.rdSel = RS_ACT;
          stb.actWr = dataWr;
        end
        IDX_BHI: if (devOk) begin
          stb.rdSel = RS_BHI;
          stb.hiWr  = dataWr;
        end
        IDX_BLO: if (devOk) begin
          stb.rdSel = RS_BLO;
          stb.loWr  = dataWr;
        end
        default: stb.rdSel = RS_NONE;
      endcase
    end
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.idxWr, stb.ldnWr, stb.actWr, stb.hiWr, stb.loWr}));
endmodule

// File: rtl/cfg_space_dp.sv
module cfg_space_dp
  import cfg_space_pkg::*;
#(
  parameter int         NUM_DEV  = 15,
  parameter logic [7:0] REV_CODE = 8'h01
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            wrData,
  input  cfgStb_t               stb,
  output logic [7:0]            idxQ,
  output logic [7:0]            ldnQ,
  output logic [7:0]            rdData,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [NUM_DEV*16-1:0] devBase
);
  localparam int SLOT_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [15:0]       baseQ [NUM_DEV];
  logic [SLOT_W-1:0] slot;

  assign slot = ldnQ[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      ldnQ <= '0;
    end else begin
      if (stb.idxWr) idxQ <= wrData;
      if (stb.ldnWr) ldnQ <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        devActive[i] <= 1'b0;
        baseQ[i]     <= '0;
      end else if (ldnQ == 8'(i)) begin
        if (stb.actWr) devActive[i]   <= wrData[0];
        if (stb.hiWr)  baseQ[i][15:8] <= wrData;
        if (stb.loWr)  baseQ[i][7:0]  <= wrData;
      end
    end
    assign devBase[i*16 +: 16] = baseQ[i];
  end

  always_comb begin
    unique case (stb.rdSel)
      RS_INDEX: rdData = idxQ;
      RS_ID:    rdData = ID_CODE;
      RS_REV:   rdData = REV_CODE;
      RS_LDN:   rdData = ldnQ;
      RS_ACT:   rdData = {7'b0, devActive[slot]};
      RS_BHI:   rdData = baseQ[slot][15:8];
      RS_BLO:   rdData = baseQ[slot][7:0];
      default:  rdData = FILL_BYTE;
    endcase
  end

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(idxQ) |-> $past(stb.idxWr));
  // R6
  act_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devActive) |-> $past(stb.actWr));
  // R6
  act_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(devActive ^ $past(devActive)) <= 1);
  // R7
  base_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devBase) |-> $past(stb.hiWr || stb.loWr));
  // R9
  bank_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.actWr || stb.hiWr || stb.loWr) |-> (ldnQ < 8'(NUM_DEV)));
endmodule

// File: rtl/cfg_index_space.sv
module cfg_index_space
  import cfg_space_pkg::*;
#(
  parameter int         NUM_DEV  = 15,
  parameter logic [7:0] REV_CODE = 8'h01
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  portSel,
  input  logic                  wrEn,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [NUM_DEV*16-1:0] devBase
);
  cfgStb_t    stb;
  logic [7:0] idxQ;
  logic [7:0] ldnQ;

  cfg_space_ctrl #(.NUM_DEV(NUM_DEV)) uCtrl (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn),
    .idxQ(idxQ), .ldnQ(ldnQ), .stb(stb)
  );

  cfg_space_dp #(.NUM_DEV(NUM_DEV), .REV_CODE(REV_CODE)) uDp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .stb(stb),
    .idxQ(idxQ), .ldnQ(ldnQ), .rdData(rdData),
    .devActive(devActive), .devBase(devBase)
  );
endmodule

// File: tb/sim_cfg_index_space.sv
module sim_cfg_index_space;
  localparam int NUM_DEV = 15;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  portSel = 1'b0;
  logic                  wrEn = 1'b0;
  logic [7:0]            wrData = '0;
  logic [7:0]            rdData;
  logic [NUM_DEV-1:0]    devActive;
  logic [NUM_DEV*16-1:0] devBase;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  cfg_index_space u0 (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .devActive(devActive), .devBase(devBase)
  );

  // vector: {req[3:0], port, wr, data[7:0], expected[7:0]}
  localparam int NVEC = 30;
  localparam logic [21:0] VEC [NVEC] = '{
    {4'd2, 1'b0, 1'b1, 8'h20, 8'h00},  // R2 set index
    {4'd2, 1'b0, 1'b0, 8'h00, 8'h20},  // R2 index readback
    {4'd3, 1'b1, 1'b0, 8'h00, 8'hE9},  // R3 identity
    {4'd3, 1'b1, 1'b1, 8'h55, 8'h00},  // R3 write ignored
    {4'd3, 1'b1, 1'b0, 8'h00, 8'hE9},
    {4'd2, 1'b0, 1'b0, 8'h00, 8'h20},  // R2 index held
    {4'd4, 1'b0, 1'b1, 8'h27, 8'h00},
    {4'd4, 1'b1, 1'b0, 8'h00, 8'h01},  // R4 revision
    {4'd4, 1'b1, 1'b1, 8'hAA, 8'h00},
    {4'd4, 1'b1, 1'b0, 8'h00, 8'h01},
    {4'd5, 1'b0, 1'b1, 8'h07, 8'h00},
    {4'd5, 1'b1, 1'b1, 8'h03, 8'h00},
    {4'd5, 1'b1, 1'b0, 8'h00, 8'h03},  // R5 ldn readback
    {4'd6, 1'b0, 1'b1, 8'h30, 8'h00},
    {4'd6, 1'b1, 1'b1, 8'hFF, 8'h00},
    {4'd6, 1'b1, 1'b0, 8'h00, 8'h01},  // R6 only bit 0
    {4'd7, 1'b0, 1'b1, 8'h60, 8'h00},
    {4'd7, 1'b1, 1'b1, 8'h12, 8'h00},
    {4'd7, 1'b1, 1'b0, 8'h00, 8'h12},  // R7 high byte
    {4'd7, 1'b0, 1'b1, 8'h61, 8'h00},
    {4'd7, 1'b1, 1'b1, 8'h34, 8'h00},
    {4'd7, 1'b1, 1'b0, 8'h00, 8'h34},  // R7 low byte
    {4'd8, 1'b0, 1'b1, 8'h55, 8'h00},
    {4'd8, 1'b1, 1'b0, 8'h00, 8'hFF},  // R8 unimplemented
    {4'd8, 1'b1, 1'b1, 8'h00, 8'h00},
    {4'd8, 1'b1, 1'b0, 8'h00, 8'hFF},
    {4'd9, 1'b0, 1'b1, 8'h07, 8'h00},
    {4'd9, 1'b1, 1'b1, 8'h0F, 8'h00},  // R9 out-of-range ldn
    {4'd9, 1'b0, 1'b1, 8'h30, 8'h00},
    {4'd9, 1'b1, 1'b0, 8'h00, 8'hFF}   // R9 read fill
  };

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [7:0] d);
    @(negedge clk);
    portSel = p; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic p, input logic [7:0] exp);
    @(negedge clk);
    portSel = p;
    #1 check(req, 256'(rdData), 256'(exp));
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", 256'(devActive), 256'(0));
    check("R1", 256'(devBase), 256'(0));
    rd("R1", 1'b0, 8'h00);
    wr(1'b0, 8'h07);
    rd("R1", 1'b1, 8'h00);

    for (int k = 0; k < NVEC; k++) begin
      logic [21:0] v;
      v = VEC[k];
      if (v[16]) wr(v[17], v[15:8]);
      else rd($sformatf("R%0d", v[21:18]), v[17], v[7:0]);
    end

    // R9: writes while ldn=0x0F changed nothing
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h60); wr(1'b1, 8'h77);
    rd("R9", 1'b1, 8'hFF);
    check("R9", 256'(devActive), 256'(15'h0008));
    // R6/R7 exported values for device 3 only
    check("R7", 256'(devBase), 256'(240'h1234) << 48);

    // R5 bank switch to device 5: fresh bank
    wr(1'b0, 8'h07); wr(1'b1, 8'h05);
    wr(1'b0, 8'h60);
    rd("R5", 1'b1, 8'h00);
    wr(1'b0, 8'h30); wr(1'b1, 8'h01);
    check("R6", 256'(devActive), 256'(15'h0028));

    // R7 boundary device 14
    wr(1'b0, 8'h07); wr(1'b1, 8'h0E);
    wr(1'b0, 8'h60); wr(1'b1, 8'hAB);
    wr(1'b0, 8'h61); wr(1'b1, 8'hCD);
    #1 check("R7", 256'(devBase[14*16 +: 16]), 256'(16'hABCD));
    // R5 back to device 3 still holds its base
    wr(1'b0, 8'h07); wr(1'b1, 8'h03);
    wr(1'b0, 8'h61);
    rd("R5", 1'b1, 8'h34);
    // R6 clear device 3
    wr(1'b0, 8'h30); wr(1'b1, 8'hFE);
    rd("R6", 1'b1, 8'h00);
    check("R6", 256'(devActive), 256'(15'h0020));

    // R1 reset again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R1", 256'(devActive), 256'(0));
    check("R1", 256'(devBase), 256'(0));

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule